// File: doc/BRIEF.md
# Three-Operand Carry-Keeping Adder

This unit adds three 64-bit integers in a single operation and registers one destination value a cycle later. The third operand usually carries the carry out of the previous limb of a multiword sum, so a wide addition is built from ordinary register traffic. No condition-code register is involved: each operation yields exactly one result word.

Three result forms are offered. The plain form writes the 64-bit sum and clears the two extra bits. The widened form writes 66 bits: bit 64 is the unsigned carry out of the three-input add and bit 65 is the signed overflow. The carry-only form writes the carry out of the same add as a small integer, which becomes the third operand of the next limb's add. A long sum therefore alternates a plain add and a carry-only op on each limb pair. The third operand is zero for the lowest limb. The sign of a result is its bit 63. The zero indication looks only at bits 63 down to 0, so the flag bits never make a value look non-zero.

Top module: `carry_add_unit`

## Requirements
- R1: For opcodes 2'b00 and 2'b01, result bits 63:0 equal (A + B + C) modulo 2^64, and bit 63 is the sign of that value.
- R2: Opcode 2'b00 (plain add) clears result bits 65:64.
- R3: Opcode 2'b01 (widened add) sets bit 64 when the unsigned sum A+B+C is at least 2^64. It sets bit 65 when the signed sum of A and B plus the unsigned C has a sign that differs from bit 63 of the truncated result.
- R4: Opcode 2'b10 (carry-only) writes the carry out of A+B+C, which is floor((A+B+C)/2^64), into bits 1:0, and zeros bits 65:2.
- R5: With C equal to 0 or 1 the carry out is 0 or 1. With arbitrary C it may be 2, and the carry-only op returns 2 in that case.
- R6: out_valid rises in the cycle after a cycle with in_valid high, and falls in the cycle after a cycle with in_valid low. The result of an accepted operation appears alongside out_valid.
- R7: While in_valid is low, out_result keeps its last value.
- R8: out_zero is high exactly when out_result bits 63:0 are all zero, whatever bits 65:64 hold.
- R9: Opcode 2'b11 is reserved and writes an all-zero result with out_valid still asserted.
- R10: After reset, out_valid is 0, out_result is 0 and out_zero is 1.
- R11: Alternating a plain add and a carry-only op over four limbs, with C = 0 on the lowest limb and C = the previous carry-only result above it, gives the correct 256-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Opcode: 00 plain, 01 widened, 10 carry-only, 11 reserved |
| in_a | input | 64 | First addend |
| in_b | input | 64 | Second addend |
| in_c | input | 64 | Third addend, normally the previous carry |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_result | output | 66 | Registered result word |
| out_zero | output | 1 | Bits 63:0 of the result are zero |

## Verification
Assertions check on every cycle the one-cycle valid timing, that the result holds while no operation is accepted, the modulo-2^64 low word of the add forms, the cleared upper bits of the plain, carry-only and reserved forms, and the bound on the carry when the carry-in is binary. Only the bench scenarios can show that the carry and overflow bits take the right value in the boundary cases. These include a signed wrap from positive to negative, two negatives wrapping to zero, and a carry of 2. The scenarios also show that the zero flag ignores the flag bits, and that a four-limb chain of plain and carry-only ops gives the full 256-bit sum.

// File: rtl/carry_add_pkg.sv
package carry_add_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_WIDE  = 2'b01,
        OP_CARRY = 2'b10,
        OP_RSVD  = 2'b11
    } cau_op_e;

    localparam int CARRY_W = 2;

endpackage

// File: rtl/cau_sum3.sv
module cau_sum3 #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]                  a,
    input  logic [XLEN-1:0]                  b,
    input  logic [XLEN-1:0]                  c,
    output logic [XLEN-1:0]                  sum,
    output logic [carry_add_pkg::CARRY_W-1:0] carry,
    output logic                             ovf
);
    localparam int UW = XLEN + carry_add_pkg::CARRY_W;

    logic [UW-1:0] usum;
    logic [2:0]    hi_signed;

    always_comb begin
        usum  = {2'b00, a} + {2'b00, b} + {2'b00, c};
        sum   = usum[XLEN-1:0];
        carry = usum[UW-1:XLEN];
        // upper bits of the signed sum: unsigned carry minus the sign weights of A and B
        hi_signed = {1'b0, carry} - {2'b00, a[XLEN-1]} - {2'b00, b[XLEN-1]};
        ovf   = hi_signed[2] ^ usum[XLEN-1];
    end

    always_comb begin
        AST_CARRY_RANGE: assert (carry != 2'd3); // R5
        if (c <= {{(XLEN-1){1'b0}}, 1'b1}) begin
            AST_CARRY_BINARY: assert (carry <= 2'd1); // R5
        end
    end

endmodule

// File: rtl/cau_pack.sv
module cau_pack #(
    parameter int XLEN = 64
) (
    input  logic [1:0]                        op,
    input  logic [XLEN-1:0]                   sum,
    input  logic [carry_add_pkg::CARRY_W-1:0] carry,
    input  logic                              ovf,
    output logic [XLEN+1:0]                   res
);
    import carry_add_pkg::*;

    localparam int RW = XLEN + 2;

    always_comb begin
        res = '0;
        case (cau_op_e'(op))
            OP_PLAIN: res = {2'b00, sum};
            OP_WIDE:  res = {ovf, |carry, sum};
            OP_CARRY: res = {{(RW-CARRY_W){1'b0}}, carry};
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/carry_add_unit.sv
module carry_add_unit #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [XLEN-1:0] in_c,
    output logic            out_valid,
    output logic [XLEN+1:0] out_result,
    output logic            out_zero
);
    import carry_add_pkg::*;

    localparam int RW = XLEN + 2;

    typedef struct packed {
        logic          valid;
        logic [RW-1:0] result;
    } cau_state_t;

    cau_state_t st_d, st_q;

    logic [XLEN-1:0]    sum_w;
    logic [CARRY_W-1:0] carry_w;
    logic               ovf_w;
    logic [RW-1:0]      packed_w;

    cau_sum3 #(.XLEN(XLEN)) u_sum3 (
        .a     (in_a),
        .b     (in_b),
        .c     (in_c),
        .sum   (sum_w),
        .carry (carry_w),
        .ovf   (ovf_w)
    );

    cau_pack #(.XLEN(XLEN)) u_pack (
        .op    (in_op),
        .sum   (sum_w),
        .carry (carry_w),
        .ovf   (ovf_w),
        .res   (packed_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = packed_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_zero   = ~|st_q.result[XLEN-1:0];

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R7
    AST_SUM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_PLAIN || in_op == OP_WIDE))
        |=> out_result[XLEN-1:0] == $past(in_a + in_b + in_c)); // R1
    AST_PLAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_PLAIN) |=> out_result[RW-1:XLEN] == 2'b00); // R2
    AST_CARRY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CARRY) |=> out_result[RW-1:CARRY_W] == '0); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_RSVD) |=> out_result == '0); // R9

endmodule

// File: tb/carry_add_unit_bench.sv
module carry_add_unit_bench;

    localparam int XLEN = 64;
    localparam logic [63:0] MAXU = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      in_op = 2'b00;
    logic [63:0]     in_a = '0, in_b = '0, in_c = '0;
    logic            out_valid;
    logic [65:0]     out_result;
    logic            out_zero;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    carry_add_unit #(.XLEN(XLEN)) u_carry_add_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_result(out_result), .out_zero(out_zero)
    );

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [65:0] model(input logic [1:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] c);
        logic [65:0] u;
        logic signed [66:0] s;
        logic cy, ov;
        u  = {2'b00, a} + {2'b00, b} + {2'b00, c};
        s  = $signed({{3{a[63]}}, a}) + $signed({{3{b[63]}}, b}) + $signed({3'b000, c});
        cy = (u[65:64] != 2'b00);
        ov = (s[66] != u[63]);
        case (op)
            2'b00:   return {2'b00, u[63:0]};
            2'b01:   return {ov, cy, u[63:0]};
            2'b10:   return {64'd0, u[65:64]};
            default: return '0;
        endcase
    endfunction

    // one accepted op; returns with the result sampled at the following negedge
    task automatic issue(input logic [1:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_and_check(input string req, input logic [1:0] op, input logic [63:0] a,
                                 input logic [63:0] b, input logic [63:0] c);
        issue(op, a, b, c);
        check(req, out_result, model(op, a, b, c));
        check("R6 valid", {65'd0, out_valid}, 66'd1);
    endtask

    task automatic t_reset();
        check("R10 valid", {65'd0, out_valid}, 66'd0);
        check("R10 result", out_result, 66'd0);
        check("R10 zero", {65'd0, out_zero}, 66'd1);
    endtask

    task automatic t_plain();
        run_and_check("R1 plain", 2'b00, 64'd5, 64'd7, 64'd1);
        run_and_check("R2 plain wraps", 2'b00, MAXU, 64'd3, 64'd1);
        check("R2 upper clear", {64'd0, out_result[65:64]}, 66'd0);
        check("R1 sign bit", {65'd0, out_result[63]}, 66'd0);
        run_and_check("R1 negative", 2'b00, 64'd1, MAXU - 64'd4, 64'd0);
        check("R1 sign bit set", {65'd0, out_result[63]}, 66'd1);
    endtask

    task automatic t_wide();
        run_and_check("R3 carry no ovf", 2'b01, MAXU, 64'd1, 64'd0);
        check("R3 bit64", {65'd0, out_result[64]}, 66'd1);
        check("R3 bit65", {65'd0, out_result[65]}, 66'd0);
        run_and_check("R3 pos ovf", 2'b01, MAXS, 64'd0, 64'd1);
        check("R3 pos ovf bits", {64'd0, out_result[65:64]}, 66'b10);
        run_and_check("R3 neg ovf", 2'b01, MINS, MINS, 64'd0);
        check("R3 neg ovf bits", {64'd0, out_result[65:64]}, 66'b11);
        run_and_check("R3 small", 2'b01, 64'd10, 64'd20, 64'd1);
    endtask

    task automatic t_carry();
        run_and_check("R4 carry 0", 2'b10, 64'd1, 64'd2, 64'd1);
        run_and_check("R4 carry 1", 2'b10, MAXU, 64'd0, 64'd1);
        check("R5 binary", out_result, 66'd1);
        run_and_check("R5 carry 2", 2'b10, MAXU, MAXU, MAXU);
        check("R5 two", out_result, 66'd2);
    endtask

    task automatic t_hold();
        run_and_check("R7 setup", 2'b00, 64'h1234, 64'h1, 64'h0);
        @(negedge clk);
        in_op = 2'b01; in_a = MAXU; in_b = MAXU; in_c = 64'd1;
        @(negedge clk);
        check("R7 hold", out_result, 66'h1235);
        check("R6 fall", {65'd0, out_valid}, 66'd0);
    endtask

    task automatic t_zero();
        run_and_check("R8 wrap", 2'b01, MAXU, 64'd1, 64'd0);
        check("R8 zero flag", {65'd0, out_zero}, 66'd1);
        run_and_check("R8 nonzero", 2'b00, 64'd0, 64'd0, 64'd1);
        check("R8 zero low", {65'd0, out_zero}, 66'd0);
    endtask

    task automatic t_rsvd();
        run_and_check("R9 reserved", 2'b11, 64'd9, 64'd9, 64'd1);
        check("R9 zero", out_result, 66'd0);
    endtask

    task automatic t_chain();
        logic [255:0] a, b, exp, got;
        logic [63:0] cin;
        a = {MAXU, 64'h0123_4567_89AB_CDEF, MAXU, MAXU};
        b = {64'd0, 64'hFEDC_BA98_7654_3210, 64'd0, 64'd1};
        exp = a + b;
        cin = '0;
        for (int i = 0; i < 4; i++) begin
            issue(2'b00, a[i*64 +: 64], b[i*64 +: 64], cin);
            got[i*64 +: 64] = out_result[63:0];
            issue(2'b10, a[i*64 +: 64], b[i*64 +: 64], cin);
            cin = out_result[63:0];
        end
        check("R11 low", {2'b00, got[127:0] == exp[127:0] ? 64'd1 : 64'd0}, 66'd1);
        check("R11 high", {2'b00, got[255:128] == exp[255:128] ? 64'd1 : 64'd0}, 66'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_plain();
        t_wide();
        t_carry();
        t_hold();
        t_zero();
        t_rsvd();
        t_chain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule